// File: doc/BRIEF.md
# Memory-Controller Event Counter Unit

This block watches a memory controller and counts what it does. It holds four counters. Counter 0 counts clock cycles and nothing else. Counters 1 to 3 each count one of several single-cycle event strobes from the controller, and an 8-bit event code picks the strobe. Software reaches the counters through a small register bus. Each counter has a control word and a count word, and the counts can be read while they run.

The cycle counter governs the whole unit. If it is disabled, or if it wraps past its top value, every counter stops. A wrap of the cycle counter also raises the single interrupt line. A wrap on counters 1 to 3 sets that counter's overflow flag and nothing else, and the counter keeps running. Software restarts a counter in two writes: first it writes zero to the control word, then it writes enable, clear and the event code in one word.

Top module: `mc_evt_mon`

## Requirements
- R1: After a synchronous reset, all counts, all control fields, `bus_rdata` and `irq` are zero.
- R2: The control word of counter n is at byte address 4*n and its count is at 0x20 + 4*n. In the control word, bit 0 is the overflow flag, bit 1 is clear (it always reads 0), bit 2 is enable and bits 31:24 are the event code. `bus_rdata` presents the addressed word one clock after the address is driven.
- R3: Counter 0 adds one on every clock while it is enabled and the unit is not halted. The event code written to it is ignored and reads back as 0.
- R4: Counters 1 to 3 add one on each clock where their selected strobe is high. The code map is 0x04 to strobe bit 0, 0x05 to bit 1, 0x20 to bit 2, 0x21 to bit 3, 0x31 to bit 4, 0x32 to bit 5 and 0x37 to bit 6. Any other code counts nothing.
- R5: The event code is taken only by a write that raises enable from 0 to 1. If that write also has the clear bit set, it zeroes the count and the overflow flag. Without the clear bit the count resumes from its held value.
- R6: A write with enable set to a counter that is already enabled changes neither its count nor its event code.
- R7: Counters 1 to 3 count only while counter 0 is enabled and the unit is not halted.
- R8: When counter 1, 2 or 3 passes its top value, it wraps to 0, sets its overflow flag, keeps counting and does not raise `irq`.
- R9: When counter 0 passes its top value, it wraps to 0 and sets its overflow flag. The unit then halts, so all counts freeze, and `irq` goes high.
- R10: `irq` is a level. It stays high until a write to counter 0's control word with enable clear, and that write also ends the halt.
- R11: Reads of any other address, including misaligned ones, return 0. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| evt_strobe | input | NUM_EVT | Single-cycle event strobes from the memory controller |
| irq | output | 1 | Level interrupt, high while halted by a cycle-counter wrap |

## Verification
A write takes effect at the first rising edge after it is driven. A strobe that is high before an edge is counted at that edge. A read returns the addressed word at the edge after the address is driven, so the value it shows is the count just before that edge. `irq` changes at the same edge as the wrap or the clearing write. The bench drives all inputs on the falling edge and samples `bus_rdata` and `irq` at the next falling edge. Because of this, each expected count is the exact number of edges or strobes between the write and the read. The one exception is the wrap test, which tracks wrapped ranges instead of exact values.

// File: rtl/mc_evt_pkg.sv
package mc_evt_pkg;
  localparam int CODE_W  = 8;
  localparam int IDX_W   = 3;
  localparam int OVF_BIT = 0;
  localparam int CLR_BIT = 1;
  localparam int EN_BIT  = 2;
  localparam int SEL_LSB = 24;

  typedef struct packed {
    logic             valid;
    logic [IDX_W-1:0] idx;
  } evt_map_t;

  // translate an event code into a strobe index
  function automatic evt_map_t evt_lookup(input logic [CODE_W-1:0] code);
    evt_map_t m;
    m = '{valid: 1'b1, idx: '0};
    case (code)
      8'h04:   m.idx = 3'd0;
      8'h05:   m.idx = 3'd1;
      8'h20:   m.idx = 3'd2;
      8'h21:   m.idx = 3'd3;
      8'h31:   m.idx = 3'd4;
      8'h32:   m.idx = 3'd5;
      8'h37:   m.idx = 3'd6;
      default: m.valid = 1'b0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/mc_evt_mux.sv
module mc_evt_mux
  import mc_evt_pkg::*;
#(
  parameter int NUM_EVT = 7
) (
  input  logic [CODE_W-1:0]  code,
  input  logic [NUM_EVT-1:0] strobes,
  output logic               hit
);
  evt_map_t m;

  always_comb begin
    m   = evt_lookup(code);
    hit = 1'b0;
    if (m.valid && (int'(m.idx) < NUM_EVT)) hit = strobes[m.idx];
  end
endmodule

// File: rtl/mc_evt_ctr.sv
module mc_evt_ctr
  import mc_evt_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int NUM_EVT  = 7,
  parameter bit IS_CYCLE = 1'b0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_hit,
  input  logic               wr_en_bit,
  input  logic               wr_clr_bit,
  input  logic [CODE_W-1:0]  wr_code,
  input  logic               run,
  input  logic [NUM_EVT-1:0] evt,
  output logic [CNT_W-1:0]   cnt_o,
  output logic               en_o,
  output logic               ovf_o,
  output logic [CODE_W-1:0]  code_o,
  output logic               wrap_o
);
  logic [CNT_W-1:0]  cnt_q;
  logic              en_q, ovf_q, mux_hit, hit, inc, arm;
  logic [CODE_W-1:0] code_q;

  mc_evt_mux #(.NUM_EVT(NUM_EVT)) u_mux (
    .code(code_q), .strobes(evt), .hit(mux_hit)
  );

  assign hit    = IS_CYCLE ? 1'b1 : mux_hit;
  assign inc    = en_q && run && hit;
  assign wrap_o = inc && (&cnt_q);
  assign arm    = wr_hit && !en_q && wr_en_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      en_q   <= 1'b0;
      ovf_q  <= 1'b0;
      code_q <= '0;
    end else begin
      if (wr_hit) en_q <= wr_en_bit;
      if (arm) code_q <= IS_CYCLE ? '0 : wr_code;
      if (arm && wr_clr_bit) begin
        cnt_q <= '0;
        ovf_q <= 1'b0;
      end else if (inc) begin
        cnt_q <= cnt_q + 1'b1;
        if (&cnt_q) ovf_q <= 1'b1;
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign en_o   = en_q;
  assign ovf_o  = ovf_q;
  assign code_o = code_q;

  // R8/R9: the overflow flag rises only from a count at its top value
  a_r8_ovf_from_top: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_q) |-> $past(&cnt_q));
  // R6: a repeated enable write leaves the event code alone
  a_r6_no_restart: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && en_q && wr_en_bit) |=> $stable(code_q));
  // R5: raising enable with clear zeroes count and flag
  a_r5_arm_clear: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && !en_q && wr_en_bit && wr_clr_bit) |=> (cnt_q == '0 && !ovf_q));
endmodule

// File: rtl/mc_evt_mon.sv
module mc_evt_mon
  import mc_evt_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int NUM_CTR = 4,
  parameter int NUM_EVT = 7,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_EVT-1:0] evt_strobe,
  output logic               irq
);
  localparam int CNT_BASE = 32'h20;

  logic [NUM_CTR-1:0]       wr_hit, en_v, ovf_v, wrap_v;
  logic [CNT_W-1:0]         cnt_arr  [NUM_CTR];
  logic [CODE_W-1:0]        code_arr [NUM_CTR];
  logic [NUM_CTR*CNT_W-1:0] cnt_flat;
  logic                     halt_q, addr_hit;
  logic [31:0]              rd_next;

  genvar n;
  generate
    for (n = 0; n < NUM_CTR; n++) begin : g_ctr
      logic run_n;
      assign wr_hit[n] = bus_wr && (bus_addr == ADDR_W'(4 * n));
      if (n == 0) begin : g_cyc
        assign run_n = !halt_q;
      end else begin : g_evt
        assign run_n = en_v[0] && !halt_q;
      end
      mc_evt_ctr #(
        .CNT_W(CNT_W), .NUM_EVT(NUM_EVT), .IS_CYCLE(n == 0)
      ) u_ctr (
        .clk(clk), .rst(rst),
        .wr_hit(wr_hit[n]),
        .wr_en_bit(bus_wdata[EN_BIT]),
        .wr_clr_bit(bus_wdata[CLR_BIT]),
        .wr_code(bus_wdata[SEL_LSB +: CODE_W]),
        .run(run_n), .evt(evt_strobe),
        .cnt_o(cnt_arr[n]), .en_o(en_v[n]), .ovf_o(ovf_v[n]),
        .code_o(code_arr[n]), .wrap_o(wrap_v[n])
      );
      assign cnt_flat[n*CNT_W +: CNT_W] = cnt_arr[n];
    end
  endgenerate

  // halt: set by a cycle-counter wrap, cleared by disabling counter 0
  always_ff @(posedge clk) begin
    if (rst)                                       halt_q <= 1'b0;
    else if (wr_hit[0] && !bus_wdata[EN_BIT])      halt_q <= 1'b0;
    else if (wrap_v[0])                            halt_q <= 1'b1;
  end
  assign irq = halt_q;

  always_comb begin
    rd_next  = '0;
    addr_hit = 1'b0;
    for (int i = 0; i < NUM_CTR; i++) begin
      if (bus_addr == ADDR_W'(4 * i)) begin
        addr_hit = 1'b1;
        rd_next  = '0;
        rd_next[SEL_LSB +: CODE_W] = code_arr[i];
        rd_next[EN_BIT]            = en_v[i];
        rd_next[OVF_BIT]           = ovf_v[i];
      end
      if (bus_addr == ADDR_W'(CNT_BASE + 4 * i)) begin
        addr_hit = 1'b1;
        rd_next  = 32'(cnt_arr[i]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

  // R9: the interrupt rises only after the cycle counter was at its top
  a_r9_irq_on_wrap: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(&cnt_arr[0]));
  // R9: while halted and untouched, no count moves
  a_r9_halt_freeze: assert property (@(posedge clk) disable iff (rst)
    (halt_q && !bus_wr) |=> $stable(cnt_flat));
  // R7: with the cycle counter disabled, no count moves
  a_r7_gate: assert property (@(posedge clk) disable iff (rst)
    (!en_v[0] && !bus_wr) |=> $stable(cnt_flat));
  // R10: the interrupt holds until counter 0 is disabled
  a_r10_irq_hold: assert property (@(posedge clk) disable iff (rst)
    (irq && !(wr_hit[0] && !bus_wdata[EN_BIT])) |=> irq);
  // R8: an event-counter wrap alone never raises the interrupt
  a_r8_quiet_wrap: assert property (@(posedge clk) disable iff (rst)
    ((|wrap_v[NUM_CTR-1:1]) && !wrap_v[0] && !irq) |=> !irq);
  // R11: unmapped addresses read as zero
  a_r11_unmapped_rd: assert property (@(posedge clk) disable iff (rst)
    !addr_hit |=> (bus_rdata == 32'h0));
endmodule

// File: tb/mc_evt_mon_bench.sv
`timescale 1ns/1ps
module mc_evt_mon_bench;
  localparam int CW = 10;
  localparam int NE = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NE-1:0] evt_strobe = '0;
  logic          irq;
  int            n_chk = 0, n_bad = 0;
  logic [31:0]   v, w;

  always #2 clk = ~clk;

  mc_evt_mon #(.CNT_W(CW), .NUM_CTR(4), .NUM_EVT(NE), .ADDR_W(8)) u_mc_evt_mon (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_strobe(evt_strobe), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic pulse(input int bit_i, input int times);
    for (int k = 0; k < times; k++) begin
      evt_strobe[bit_i] = 1'b1;
      @(negedge clk);
      evt_strobe[bit_i] = 1'b0;
    end
  endtask

  task automatic t_reset;
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 rdata", bus_rdata, 32'h0);
    rd(8'h00, v); chk("R1 ctrl0", v, 32'h0);
    rd(8'h24, v); chk("R1 cnt1", v, 32'h0);
  endtask

  task automatic t_cycle;
    wr(8'h00, 32'h0400_0006);
    repeat (5) @(negedge clk);
    rd(8'h20, v); chk("R3 cycle count", v, 32'd5);
    rd(8'h00, v); chk("R2 R3 ctrl0 readback", v, 32'h0000_0004);
  endtask

  task automatic t_event;
    wr(8'h04, 32'h0400_0006);
    pulse(0, 3); pulse(1, 2);
    rd(8'h24, v); chk("R4 code 04 count", v, 32'd3);
    rd(8'h04, v); chk("R2 ctrl1 readback", v, 32'h0400_0004);
    wr(8'h04, 32'h2100_0006);
    rd(8'h24, v); chk("R6 count kept", v, 32'd3);
    rd(8'h04, v); chk("R6 code kept", v, 32'h0400_0004);
    pulse(3, 1);
    rd(8'h24, v); chk("R6 old code still selects", v, 32'd3);
    wr(8'h08, 32'h3200_0006);
    pulse(5, 4); pulse(0, 1);
    rd(8'h28, v); chk("R4 code 32 count", v, 32'd4);
    wr(8'h0C, 32'h7700_0006);
    evt_strobe = '1; repeat (2) @(negedge clk); evt_strobe = '0;
    rd(8'h2C, v); chk("R4 unmapped code counts nothing", v, 32'd0);
    rd(8'h24, v); chk("R4 cnt1 total", v, 32'd6);
  endtask

  task automatic t_resume;
    wr(8'h04, 32'h0);
    pulse(0, 2);
    rd(8'h24, v); chk("R5 disabled holds", v, 32'd6);
    wr(8'h04, 32'h0500_0004);
    pulse(1, 1); pulse(0, 1);
    rd(8'h24, v); chk("R5 resume without clear", v, 32'd7);
    rd(8'h04, v); chk("R5 new code taken", v, 32'h0500_0004);
    wr(8'h04, 32'h0);
    wr(8'h04, 32'h0500_0006);
    rd(8'h24, v); chk("R5 clear on enable", v, 32'd0);
  endtask

  task automatic t_gate;
    wr(8'h00, 32'h0);
    pulse(1, 3);
    rd(8'h24, v); chk("R7 gated by cycle disable", v, 32'd0);
    rd(8'h20, v); rd(8'h20, w); chk("R7 cycle frozen", w, v);
    wr(8'h00, 32'h0000_0006);
    pulse(1, 1);
    rd(8'h24, v); chk("R7 counts after restart", v, 32'd1);
  endtask

  task automatic t_evt_wrap;
    evt_strobe[1] = 1'b1;
    repeat (600) @(negedge clk);
    wr(8'h00, 32'h0);
    wr(8'h00, 32'h0000_0006);
    repeat (500) @(negedge clk);
    evt_strobe[1] = 1'b0;
    chk("R8 no irq on event wrap", {31'b0, irq}, 32'h0);
    rd(8'h04, v); chk("R8 ovf flag set", v, 32'h0500_0005);
    rd(8'h24, v);
    chk("R8 wrapped count small", {31'b0, (v < 32'd200)}, 32'h1);
    pulse(1, 1);
    rd(8'h24, w); chk("R8 keeps counting", w, v + 32'd1);
  endtask

  task automatic t_cyc_wrap;
    repeat (700) @(negedge clk);
    chk("R9 irq raised", {31'b0, irq}, 32'h1);
    rd(8'h20, v); chk("R9 cycle wrapped and froze", v, 32'd0);
    rd(8'h00, v); chk("R9 cycle ovf flag", v, 32'h0000_0005);
    rd(8'h24, v); pulse(1, 3);
    rd(8'h24, w); chk("R9 event counter frozen", w, v);
  endtask

  task automatic t_irq_clear;
    repeat (5) @(negedge clk);
    chk("R10 irq held", {31'b0, irq}, 32'h1);
    wr(8'h00, 32'h0);
    chk("R10 irq cleared", {31'b0, irq}, 32'h0);
    rd(8'h00, v); chk("R10 ctrl0 after clear", v, 32'h0000_0001);
    wr(8'h00, 32'h0000_0006);
    rd(8'h00, v); chk("R5 ctrl0 rearmed", v, 32'h0000_0004);
  endtask

  task automatic t_unmapped;
    rd(8'h10, v); chk("R11 read 0x10", v, 32'h0);
    rd(8'h40, v); chk("R11 read 0x40", v, 32'h0);
    rd(8'h22, v); chk("R11 misaligned read", v, 32'h0);
    rd(8'h24, w);
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h30, 32'hFFFF_FFFF);
    wr(8'h06, 32'hFFFF_FFFF);
    rd(8'h24, v); chk("R11 cnt1 untouched", v, w);
    rd(8'h04, v); chk("R11 ctrl1 untouched", v, 32'h0500_0005);
    chk("R11 irq untouched", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_cycle;
    t_event;
    t_resume;
    t_gate;
    t_evt_wrap;
    t_cyc_wrap;
    t_irq_clear;
    t_unmapped;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule